// File: doc/BRIEF.md
# UART Interrupt Aggregation Controller

This block merges six interrupt causes around a buffered UART into a single active-high request line for an external bus. It watches the UART's own interrupt and the fill levels of the 16-entry receive and transmit buffers. It times how long received data sits unread. It also observes the modem-status lines (three per port) of two modem ports. Each cause that fires sets a sticky bit in a source vector, which software reads to learn what happened. A read strobe on that vector clears it. A per-source mask decides which sticky bits drive the request output.

The buffers, the UART and the bus decoder sit outside. The block sees buffer levels as plain numbers, a push strobe for each received character, a pop strobe for each buffer read, and a one-cycle tick for each character time. The port-routing code tells it which modem port currently feeds the UART. Activity is reported only on ports that are not routed. All pins are plain control and status levels or strobes. No data stream crosses the block, so there is no handshake and no back-pressure.

Top module: `uart_irq_agg`

## Requirements
- R1: After reset, `src_q` is all zeros and `irq` is low.
- R2: A cycle with `uart_irq` high sets `src_q[0]` at the next clock edge.
- R3: `src_q[1]` is set in the cycle after `rx_level` goes from below 8 to 8 or more. It is not set again while the level stays at 8 or above, whatever the level does in that range.
- R4: `src_q[3]` is set in the cycle after `tx_level` goes from above 8 to 8 or less. It is not set again while the level stays at 8 or below. After reset the transmit side counts as already at or below 8.
- R5: `src_q[2]` is set at the fourth `char_tick` that arrives while `rx_level` is non-zero and no `rx_push` or `rx_pop` has occurred since the count last restarted. It fires only once per such idle stretch.
- R6: An `rx_push` or `rx_pop` cycle restarts the idle count. An empty receive buffer holds the count at zero, so ticks while empty never set `src_q[2]`.
- R7: Each modem input passes through a two-flop synchronizer. A toggle on any of the three status lines of port 1 sets `src_q[4]` within four clock cycles when `port_sel` is not 1. A toggle on port 2 does the same for `src_q[5]` when `port_sel` is not 2. The `port_sel` codes are 0 for the infrared port, 1 for modem port 1, 2 for modem port 2, and 3 for no port.
- R8: A toggle on the port that `port_sel` routes to the UART leaves its activity bit clear.
- R9: A cycle with `src_rd` high clears every bit of `src_q` at the next edge. A cause that fires in that same cycle still leaves its bit set.
- R10: `irq` is high exactly when some bit is set in both `src_q` and `mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uart_irq | input | 1 | Interrupt from the UART core |
| rx_level | input | 5 | Receive buffer occupancy, 0 to 16 |
| tx_level | input | 5 | Transmit buffer occupancy, 0 to 16 |
| rx_push | input | 1 | A character entered the receive buffer |
| rx_pop | input | 1 | The bus read the receive buffer |
| char_tick | input | 1 | One-cycle pulse per character time |
| port_sel | input | 2 | Routing code: 0 infrared, 1 modem 1, 2 modem 2 |
| m1_status | input | 3 | Raw modem-status lines of port 1 |
| m2_status | input | 3 | Raw modem-status lines of port 2 |
| mask | input | 6 | Enable per source bit |
| src_rd | input | 1 | Read strobe of the source vector, clears it |
| src_q | output | 6 | Sticky source bits |
| irq | output | 1 | Combined interrupt, active high |

## Verification
A wrong threshold register or a stale idle counter is visible directly in `src_q`. It shows one edge after the offending level change or tick, either as a bit that sets one step early or late or as a bit that sets again without a new crossing. A broken synchronizer or a broken port-select decode shows as a wrong activity bit within four cycles of a toggle. A bad mask path shows in `irq` in the same cycle as the mask change, because that path holds no state.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NSRC      = 6;
  localparam int SRC_UART  = 0;
  localparam int SRC_RXHF  = 1;
  localparam int SRC_RXTMO = 2;
  localparam int SRC_TXHE  = 3;
  localparam int SRC_PORT0 = 4;
  localparam int NPORT     = 2;
  localparam int NSIG      = 3;
endpackage

// File: rtl/irq_level_edge.sv
module irq_level_edge #(
  parameter int W      = 5,
  parameter int THRESH = 8,
  parameter bit UPWARD = 1'b1,
  parameter bit INIT   = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic         fire
);
  logic cond, cond_q;

  generate
    if (UPWARD) begin : g_up
      assign cond = level >= W'(THRESH);
    end else begin : g_down
      assign cond = level <= W'(THRESH);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= INIT;
    else        cond_q <= cond;
  end

  assign fire = cond & ~cond_q;

  // R3
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/irq_rx_timeout.sv
module irq_rx_timeout #(
  parameter int LVL_W     = 5,
  parameter int TMO_CHARS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  output logic             fire
);
  localparam int CW = $clog2(TMO_CHARS + 2);

  logic [CW-1:0] cnt;
  logic          restart;

  assign restart = (rx_level == '0) | rx_push | rx_pop;
  assign fire    = char_tick & ~restart & (cnt == CW'(TMO_CHARS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      cnt <= '0;
    else if (restart)                                cnt <= '0;
    else if (char_tick && cnt <= CW'(TMO_CHARS))     cnt <= cnt + 1'b1;
  end

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push || rx_pop) |=> cnt == '0);

  // R5
  once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
  parameter int NSIG = 3,
  parameter bit IDLE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] lines,
  input  logic            routed,
  output logic            fire
);
  logic [NSIG-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= {NSIG{IDLE}};
      s2 <= {NSIG{IDLE}};
      s3 <= {NSIG{IDLE}};
    end else begin
      s1 <= lines;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign fire = (|(s2 ^ s3)) & ~routed;

  // R7
  steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(s2) |=> !fire || !$stable(s2));
endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int TMO_CHARS = 3,
  localparam int LVL_W    = $clog2(DEPTH + 1),
  localparam int HALF     = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uart_irq,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  input  logic [1:0]       port_sel,
  input  logic [NSIG-1:0]  m1_status,
  input  logic [NSIG-1:0]  m2_status,
  input  logic [NSRC-1:0]  mask,
  input  logic             src_rd,
  output logic [NSRC-1:0]  src_q,
  output logic             irq
);
  logic [NSRC-1:0] set_vec;
  logic [NSIG-1:0] port_lines [NPORT];

  assign port_lines[0] = m1_status;
  assign port_lines[1] = m2_status;
  assign set_vec[SRC_UART] = uart_irq;

  irq_level_edge #(.W(LVL_W), .THRESH(HALF), .UPWARD(1'b1), .INIT(1'b0)) u_rxhf (
    .clk(clk), .rst_n(rst_n), .level(rx_level), .fire(set_vec[SRC_RXHF]));

  irq_level_edge #(.W(LVL_W), .THRESH(HALF), .UPWARD(1'b0), .INIT(1'b1)) u_txhe (
    .clk(clk), .rst_n(rst_n), .level(tx_level), .fire(set_vec[SRC_TXHE]));

  irq_rx_timeout #(.LVL_W(LVL_W), .TMO_CHARS(TMO_CHARS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_push(rx_push),
    .rx_pop(rx_pop), .char_tick(char_tick), .fire(set_vec[SRC_RXTMO]));

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    irq_port_watch #(.NSIG(NSIG), .IDLE(1'b1)) u_watch (
      .clk(clk), .rst_n(rst_n), .lines(port_lines[p]),
      .routed(port_sel == 2'(p + 1)), .fire(set_vec[SRC_PORT0 + p]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= '0;
    else if (src_rd) src_q <= set_vec;
    else             src_q <= src_q | set_vec;
  end

  assign irq = |(src_q & mask);

  // R2
  uart_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uart_irq |=> src_q[SRC_UART]);

  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd && set_vec == '0) |=> src_q == '0);

  // R10
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == '0) |-> !irq);
endmodule

// File: tb/tb_uart_irq_agg.sv
module tb_uart_irq_agg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       uart_irq = 1'b0;
  logic [4:0] rx_level = '0;
  logic [4:0] tx_level = '0;
  logic       rx_push = 1'b0;
  logic       rx_pop = 1'b0;
  logic       char_tick = 1'b0;
  logic [1:0] port_sel = 2'd0;
  logic [2:0] m1_status = 3'b111;
  logic [2:0] m2_status = 3'b111;
  logic [5:0] mask = '0;
  logic       src_rd = 1'b0;
  logic [5:0] src_q;
  logic       irq;

  int nvec = 0;
  int nerr = 0;

  uart_irq_agg dut (
    .clk(clk), .rst_n(rst_n), .uart_irq(uart_irq), .rx_level(rx_level),
    .tx_level(tx_level), .rx_push(rx_push), .rx_pop(rx_pop),
    .char_tick(char_tick), .port_sel(port_sel), .m1_status(m1_status),
    .m2_status(m2_status), .mask(mask), .src_rd(src_rd), .src_q(src_q), .irq(irq));

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_src();
    src_rd = 1'b1;
    cyc(1);
    src_rd = 1'b0;
  endtask

  task automatic tick();
    char_tick = 1'b1;
    cyc(1);
    char_tick = 1'b0;
    cyc(1);
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    cyc(2);
    check("R1 src", src_q, 0);
    check("R1 irq", irq, 0);
    rst_n = 1'b1;
    cyc(3);
    check("R1 src after release", src_q, 0);

    // R2
    uart_irq = 1'b1; cyc(1); uart_irq = 1'b0;
    check("R2", src_q, 1);
    cyc(2);
    check("R2 sticky", src_q, 1);
    // R9 plain clear
    clear_src();
    check("R9 clear", src_q, 0);

    // R3 upward sweep
    for (int l = 1; l <= 16; l++) begin
      rx_level = 5'(l); cyc(1);
      check("R3 sweep", src_q[1], (l >= 8) ? 1 : 0);
    end
    clear_src();
    for (int l = 15; l >= 9; l--) begin
      rx_level = 5'(l); cyc(1);
      check("R3 no retrigger", src_q[1], 0);
    end
    rx_level = 5'd12; cyc(1);
    check("R3 no retrigger up", src_q[1], 0);
    rx_level = 5'd7; cyc(1);
    check("R3 below", src_q[1], 0);
    rx_level = 5'd8; cyc(1);
    check("R3 recross", src_q[1], 1);
    rx_level = 5'd0; cyc(1);
    clear_src();

    // R4
    for (int l = 1; l <= 16; l++) begin
      tx_level = 5'(l); cyc(1);
      check("R4 fill", src_q[3], 0);
    end
    for (int l = 15; l >= 0; l--) begin
      tx_level = 5'(l); cyc(1);
      check("R4 drain", src_q[3], (l <= 8) ? 1 : 0);
    end
    clear_src();
    tx_level = 5'd5; cyc(2);
    check("R4 no retrigger", src_q[3], 0);
    tx_level = 5'd0;

    // R5
    rx_level = 5'd3; rx_push = 1'b1; cyc(1); rx_push = 1'b0;
    clear_src();
    for (int k = 1; k <= 4; k++) begin
      tick();
      check("R5 idle ticks", src_q[2], (k >= 4) ? 1 : 0);
    end
    clear_src();
    tick(); tick();
    check("R5 fires once", src_q[2], 0);

    // R6
    rx_push = 1'b1; cyc(1); rx_push = 1'b0;
    tick(); tick(); tick();
    rx_push = 1'b1; cyc(1); rx_push = 1'b0;
    tick(); tick(); tick();
    check("R6 push restart", src_q[2], 0);
    rx_pop = 1'b1; cyc(1); rx_pop = 1'b0;
    tick(); tick(); tick();
    check("R6 pop restart", src_q[2], 0);
    tick();
    check("R6 after restart", src_q[2], 1);
    clear_src();
    rx_level = 5'd0;
    for (int k = 0; k < 6; k++) tick();
    check("R6 empty", src_q[2], 0);
    check("R6 src clean", src_q, 0);

    // R7 and R8
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 2; p++) begin
        for (int b = 0; b < 3; b++) begin
          port_sel = 2'(s);
          cyc(4);
          clear_src();
          if (p == 0) m1_status[b] = ~m1_status[b];
          else        m2_status[b] = ~m2_status[b];
          cyc(4);
          if (s == p + 1) begin
            check("R8 routed port ignored", src_q[4 + p], 0);
          end else begin
            check("R7 activity", src_q[4 + p], 1);
          end
          check("R7 other port", src_q[5 - p], 0);
        end
      end
    end
    port_sel = 2'd0;
    cyc(4);
    clear_src();

    // R9 same-cycle set wins
    uart_irq = 1'b1; cyc(1);
    src_rd = 1'b1; cyc(1);
    src_rd = 1'b0; uart_irq = 1'b0;
    check("R9 set wins", src_q, 1);

    // R10 mask sweep with bits 0 and 4 set
    m1_status[0] = ~m1_status[0];
    cyc(4);
    check("R10 setup", src_q, 17);
    for (int m = 0; m < 64; m++) begin
      mask = 6'(m);
      #1;
      check("R10 mask", irq, (m[0] | m[4]) ? 1 : 0);
    end
    mask = '1;
    clear_src();
    #1;
    check("R10 cleared", irq, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule